// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block is the device end of a two-port configuration window on an 8-bit I/O bus. One port carries a register index and the other carries register data. A host first writes an index into the index port, then reads or writes the data port to reach the selected register. The decode that recognises the two port addresses lies outside the block. The block receives a one-bit port selector (0 = index port at the base address, 1 = data port at base+1), a write strobe and write data, and it returns read data combinationally for whichever port is selected.

The window is closed after reset. Writing the opening key 0x55 to the index port opens it. Writing the closing key 0xAA to the index port closes it again. While the window is open, a select register chooses one of several logical devices. Three registers are banked by that selection, and only the embedded-controller device (number 0x0C) has real storage behind them: an activate bit and a 16-bit base address. The low byte of the base address sits at the lower index, which is the reverse of the usual order. The block drives the base address and the activate bit out to downstream decode logic. A fixed chip identifier can also be read; a parameter picks 0xC6 or 0xC7.

Top module: `cfgp_port`

## Requirements
- R1: After reset the window is closed. Both ports read 0xFF, the base-address output is 0x0000 and the enable output is 0. The stored index, device select, activate bit and base bytes all reset to 0x00.
- R2: While the window is closed, data-port writes change nothing. Index-port writes of any value other than 0x55 change nothing. Both ports read 0xFF.
- R3: An index-port write of 0x55 while the window is closed opens it from the next cycle. That key is not stored as an index.
- R4: An index-port write of 0xAA while the window is open closes it from the next cycle. That key is not stored as an index. All register contents, including the stored index, are kept across the close and the next open.
- R5: While the window is open, an index-port write of any value other than 0xAA stores that value as the index. The index port then reads it back from the next cycle.
- R6: Index 0x07 is the device select register. It is readable and writable over all 8 bits.
- R7: Index 0x20 reads the chip identifier: 0xC6 with ALT_ID=0, or 0xC7 with ALT_ID=1. Writes to it have no effect.
- R8: With device 0x0C selected, bit 0 of index 0x30 is the activate bit. Bits 7:1 read 0. The enable output follows a write in the next cycle.
- R9: With device 0x0C selected, index 0x66 holds bits 7:0 and index 0x67 holds bits 15:8 of the base-address output. Both are readable and writable, and the output follows a write in the next cycle.
- R10: With any other device selected, indexes 0x30, 0x66 and 0x67 read 0x00, and writes to them leave the enable and base outputs unchanged.
- R11: Any other index reads 0x00 while the window is open, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| ec_base | output | 16 | Base address of the embedded-controller device |
| ec_enable | output | 1 | Activate bit of the embedded-controller device |

## Verification
Every write takes effect at the clock edge where its strobe is sampled. Read data is combinational, so the result of a write is due on the read port, the base output and the enable output one cycle after the write, and a read needs no cycle of its own. The bench drives its inputs just after the falling edge. It compares every output against a behavioural model on each falling edge, and it makes directed reads a few nanoseconds after the inputs settle, well clear of the rising edge.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CFG_W = 8;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    // fixed register indexes; the host software decodes these
    localparam cfg_byte_t IDX_LDSEL = 8'h07;
    localparam cfg_byte_t IDX_CHIP  = 8'h20;
    localparam cfg_byte_t IDX_ACT   = 8'h30;
    localparam cfg_byte_t IDX_BLO   = 8'h66;
    localparam cfg_byte_t IDX_BHI   = 8'h67;

    typedef struct packed {
        cfg_byte_t idx;
        cfg_byte_t ldn;
        logic      act;
        cfg_byte_t blo;
        cfg_byte_t bhi;
    } cfg_regs_t;

endpackage

// File: rtl/cfgp_key_lock.sv
module cfgp_key_lock
    import cfgp_pkg::*;
#(
    parameter cfg_byte_t KEY_OPEN  = 8'h55,
    parameter cfg_byte_t KEY_CLOSE = 8'hAA
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idx_wr,
    input  cfg_byte_t wdata,
    output logic      unlocked,
    output logic      idx_take
);

    typedef struct packed {
        logic open;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d   = lock_q;
        idx_take = 1'b0;
        if (idx_wr) begin
            if (!lock_q.open) begin
                if (wdata == KEY_OPEN) lock_d.open = 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                lock_d.open = 1'b0;
            end else begin
                idx_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign unlocked = lock_q.open;

    // R3
    open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && idx_wr && wdata == KEY_OPEN) |=> unlocked);

    // R4
    close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter cfg_byte_t EC_LDN = 8'h0C
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      unlocked,
    input  logic      idx_take,
    input  logic      data_wr,
    input  cfg_byte_t wdata,
    output cfg_regs_t regs
);

    cfg_regs_t regs_d, regs_q;
    logic      ec_sel;

    assign ec_sel = (regs_q.ldn == EC_LDN);

    always_comb begin
        regs_d = regs_q;
        if (idx_take) regs_d.idx = wdata;
        if (data_wr && unlocked) begin
            unique case (regs_q.idx)
                IDX_LDSEL: regs_d.ldn = wdata;
                IDX_ACT:   if (ec_sel) regs_d.act = wdata[0];
                IDX_BLO:   if (ec_sel) regs_d.blo = wdata;
                IDX_BHI:   if (ec_sel) regs_d.bhi = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked) |=> ($stable(regs_q.ldn) && $stable(regs_q.act) &&
                         $stable(regs_q.blo) && $stable(regs_q.bhi)));

    // R10
    other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ec_sel && data_wr) |=> ($stable(regs_q.act) && $stable(regs_q.blo) &&
                                  $stable(regs_q.bhi)));

endmodule

// File: rtl/cfgp_rd_mux.sv
module cfgp_rd_mux
    import cfgp_pkg::*;
#(
    parameter cfg_byte_t EC_LDN  = 8'h0C,
    parameter cfg_byte_t CHIP_ID = 8'hC6
) (
    input  logic      unlocked,
    input  logic      port_sel,
    input  cfg_regs_t regs,
    output cfg_byte_t rdata
);

    logic ec_sel;
    assign ec_sel = (regs.ldn == EC_LDN);

    always_comb begin
        rdata = '0;
        if (!unlocked) begin
            rdata = '1;
        end else if (!port_sel) begin
            rdata = regs.idx;
        end else begin
            unique case (regs.idx)
                IDX_LDSEL: rdata = regs.ldn;
                IDX_CHIP:  rdata = CHIP_ID;
                IDX_ACT:   rdata = ec_sel ? {7'd0, regs.act} : '0;
                IDX_BLO:   rdata = ec_sel ? regs.blo : '0;
                IDX_BHI:   rdata = ec_sel ? regs.bhi : '0;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter bit        ALT_ID    = 1'b0,
    parameter cfg_byte_t EC_LDN    = 8'h0C,
    parameter cfg_byte_t KEY_OPEN  = 8'h55,
    parameter cfg_byte_t KEY_CLOSE = 8'hAA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [15:0] ec_base,
    output logic        ec_enable
);

    localparam cfg_byte_t CHIP_ID = ALT_ID ? 8'hC7 : 8'hC6;

    logic      unlocked;
    logic      idx_take;
    cfg_regs_t regs;

    cfgp_key_lock #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (bus_wr && !port_sel),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .idx_take (idx_take)
    );

    cfgp_regfile #(.EC_LDN(EC_LDN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlocked (unlocked),
        .idx_take (idx_take),
        .data_wr  (bus_wr && port_sel),
        .wdata    (bus_wdata),
        .regs     (regs)
    );

    cfgp_rd_mux #(.EC_LDN(EC_LDN), .CHIP_ID(CHIP_ID)) u_mux (
        .unlocked (unlocked),
        .port_sel (port_sel),
        .regs     (regs),
        .rdata    (bus_rdata)
    );

    assign ec_base   = {regs.bhi, regs.blo};
    assign ec_enable = regs.act;

    // R2
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked) |-> (bus_rdata == 8'hFF));

    // R7
    chip_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && port_sel && regs.idx == IDX_CHIP) |-> (bus_rdata == CHIP_ID));

    // R8
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && port_sel && regs.idx == IDX_ACT && regs.ldn == EC_LDN)
        |=> (ec_enable == $past(bus_wdata[0])));

    // R9
    base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && port_sel && regs.idx == IDX_BLO && regs.ldn == EC_LDN)
        |=> (ec_base[7:0] == $past(bus_wdata)));

endmodule

// File: tb/cfgp_port_tb_top.sv
module cfgp_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] ec_base;
    logic        ec_enable;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfgp_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_sel  (port_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ec_base   (ec_base),
        .ec_enable (ec_enable)
    );

    // behavioural reference model
    bit       m_open;
    int       m_idx;
    int       m_ldn;
    int       m_store [int];

    function automatic int m_key(int ldn, int idx);
        return ldn * 256 + idx;
    endfunction

    function automatic int m_get(int ldn, int idx);
        if (m_store.exists(m_key(ldn, idx))) return m_store[m_key(ldn, idx)];
        return 0;
    endfunction

    function automatic int m_read(bit sel);
        if (!m_open) return 8'hFF;
        if (!sel) return m_idx;
        if (m_idx == 8'h07) return m_ldn;
        if (m_idx == 8'h20) return 8'hC6;
        if (m_ldn == 8'h0C && (m_idx == 8'h30 || m_idx == 8'h66 || m_idx == 8'h67))
            return m_get(m_ldn, m_idx);
        return 0;
    endfunction

    function automatic string m_tag(bit sel);
        if (!m_open) return "R2";
        if (!sel) return "R5";
        if (m_idx == 8'h07) return "R6";
        if (m_idx == 8'h20) return "R7";
        if (m_idx == 8'h30 || m_idx == 8'h66 || m_idx == 8'h67)
            return (m_ldn == 8'h0C) ? ((m_idx == 8'h30) ? "R8" : "R9") : "R10";
        return "R11";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_idx = 0; m_ldn = 0;
            m_store.delete();
        end else if (bus_wr) begin
            if (!port_sel) begin
                if (!m_open) begin
                    if (bus_wdata == 8'h55) m_open = 1;
                end else if (bus_wdata == 8'hAA) m_open = 0;
                else m_idx = bus_wdata;
            end else if (m_open) begin
                if (m_idx == 8'h07) m_ldn = bus_wdata;
                else if (m_ldn == 8'h0C && m_idx == 8'h30) m_store[m_key(m_ldn, m_idx)] = bus_wdata & 1;
                else if (m_ldn == 8'h0C && (m_idx == 8'h66 || m_idx == 8'h67))
                    m_store[m_key(m_ldn, m_idx)] = bus_wdata;
            end
        end
    end

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(m_tag(port_sel), bus_rdata, m_read(port_sel));
            check("R9", ec_base, m_get(8'h0C, 8'h66) + 256 * m_get(8'h0C, 8'h67));
            check("R8", ec_enable, m_get(8'h0C, 8'h30));
        end
    end

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); #1;
        port_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(bit sel, string tag, int exp);
        @(negedge clk); #1;
        port_sel = sel; bus_wr = 1'b0;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(1, "R1", 8'hFF);
        rd(0, "R1", 8'hFF);
        check("R1", ec_base, 16'h0000);
        check("R1", ec_enable, 0);
        // R2 closed window ignores writes
        wr(1, 8'h12);
        wr(0, 8'h30);
        rd(1, "R2", 8'hFF);
        // R3 open; index not captured while closed
        wr(0, 8'h55);
        rd(0, "R3", 8'h00);
        // R6 device select
        wr(0, 8'h07); wr(1, 8'h0C);
        rd(1, "R6", 8'h0C);
        // R7 chip id, read only
        wr(0, 8'h20); wr(1, 8'h33);
        rd(1, "R7", 8'hC6);
        // R8 activate
        wr(0, 8'h30); wr(1, 8'hFF);
        rd(1, "R8", 8'h01);
        check("R8", ec_enable, 1);
        // R9 base bytes, low at lower index
        wr(0, 8'h66); wr(1, 8'h34);
        wr(0, 8'h67); wr(1, 8'h12);
        rd(1, "R9", 8'h12);
        check("R9", ec_base, 16'h1234);
        // R5 index readback
        rd(0, "R5", 8'h67);
        // R10 other bank
        wr(0, 8'h07); wr(1, 8'h05);
        wr(0, 8'h30); wr(1, 8'h00);
        rd(1, "R10", 8'h00);
        check("R10", ec_enable, 1);
        wr(0, 8'h66); wr(1, 8'hEE);
        rd(1, "R10", 8'h00);
        check("R10", ec_base, 16'h1234);
        wr(0, 8'h07); wr(1, 8'h0C);
        wr(0, 8'h30);
        rd(1, "R10", 8'h01);
        // R11 unimplemented index
        wr(0, 8'h44); wr(1, 8'h99);
        rd(1, "R11", 8'h00);
        // R4 close, contents kept
        wr(0, 8'hAA);
        rd(1, "R4", 8'hFF);
        rd(0, "R4", 8'hFF);
        wr(1, 8'h00);
        wr(0, 8'h66);
        check("R2", ec_base, 16'h1234);
        wr(0, 8'h55);
        rd(0, "R4", 8'h44);
        wr(0, 8'h66);
        rd(1, "R4", 8'h34);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule